// File: doc/BRIEF.md
# Dual-Carrier Scaled-Duty PWM Generator

This block produces the two gate signals for a two-phase boost stage whose phases are connected input-parallel and output-series. A single up/down counter forms a triangular carrier that climbs from 0 to a programmable peak P and falls back to 0, so one switching period is 2·P clock cycles. The second carrier is the mirror image (P minus count), which places it half a period away from the first. The upper gate compares the first carrier with a base duty level D. The lower gate compares the mirrored carrier with a scaled level k·D, where k is an unsigned fixed-point ratio with 8 fraction bits. This lets the two phases run at unequal but linked duty cycles, which is what input-current and output-voltage ripple cancellation needs. A gate value of 1 means the transistor conducts.

The duty, ratio and period inputs are plain level inputs with no handshake, because they are sampled and not streamed. All three are captured together only while the carrier sits at its valley. A one-cycle strobe marks each carrier peak so that a control loop can sample in the middle of the ripple. With a 100 MHz clock, a period setting of 1000 gives 50 kHz, and a ratio of 154 gives k ≈ 0.6.

Top module: `dual_pwm_gen`

## Requirements
- R1: The carrier counts 0,1,…,P,…,1 and repeats, so consecutive peak strobes are exactly 2·P cycles apart.
- R2: For 0 < D < P, the upper gate is high for exactly 2·D cycles of every 2·P-cycle period.
- R3: The lower gate is high for 2·L cycles per period, where L = min(P, floor(D·K/256)) and K is the 9-bit ratio input (bits 7:0 are fraction bits).
- R4: A captured duty of 0 keeps both gates low for the whole period.
- R5: A captured duty at or above P holds the upper gate high for every cycle.
- R6: In the cycle in which the peak strobe is high, the upper gate is low when D < P, and the lower gate is high when L > 0.
- R7: Duty, ratio and period are captured only at the carrier valley. A change made after a peak does not alter the gate output before the next valley.
- R8: The peak strobe is high for exactly one cycle per period.
- R9: While reset is asserted, both gates and the strobe are low.
- R10: A period setting of 0 behaves as a period setting of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | CW | Base duty level D, in counter steps |
| ratio_i | input | KW | Phase ratio k, unsigned, KF fraction bits |
| period_i | input | CW | Carrier peak P (half the switching period) |
| gate_upper_o | output | 1 | Upper switch drive, 1 = conducting |
| gate_lower_o | output | 1 | Lower switch drive, 1 = conducting |
| peak_stb_o | output | 1 | One-cycle pulse at each carrier peak |

## Verification
The gates and the strobe are each registered once after the counter, so all three move in the same cycle. This means phase checks can be taken in the strobe cycle itself. A new setting only takes effect after a valley, so the bench waits for two strobes after any change before it measures. It then counts high cycles over one full 2·P window, which gives the same count whatever the alignment. The capture check is the exception: it changes the duty right after a strobe and counts only the P following cycles, all of which fall before the next valley.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
  localparam int NUM_PHASES = 2;
endpackage

// File: rtl/pwm_tri_carrier.sv
module pwm_tri_carrier
  import dual_pwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] pk_o,
  output logic          rising_o,
  output logic          valley_o,
  output logic          at_peak_o
);
  logic [CW-1:0] cnt_q, pk_q, pk_in, pk_use;
  dir_e          dir_q;

  // a zero period is promoted to one so the carrier never stalls
  assign pk_in    = (period_i == '0) ? CW'(1) : period_i;
  assign valley_o = (cnt_q == '0);
  // at the valley the freshly captured peak already bounds the next climb
  assign pk_use   = valley_o ? pk_in : pk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pk_q  <= CW'(1);
      dir_q <= DIR_UP;
    end else begin
      if (valley_o) pk_q <= pk_in;
      if (dir_q == DIR_UP) begin
        if (({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, pk_use}) begin
          cnt_q <= pk_use;
          dir_q <= DIR_DOWN;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q <= CW'(1)) begin
          cnt_q <= '0;
          dir_q <= DIR_UP;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign pk_o      = pk_q;
  assign rising_o  = (dir_q == DIR_UP);
  assign at_peak_o = (cnt_q == pk_q);
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int CW = 12,
  parameter int KW = 9,
  parameter int KF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] duty_i,
  input  logic [KW-1:0] ratio_i,
  input  logic [CW-1:0] pk_i,
  output logic [CW-1:0] lvl_a_o,
  output logic [CW-1:0] lvl_b_o
);
  localparam int PW = CW + KW;

  logic [CW-1:0] duty_q;
  logic [KW-1:0] ratio_q;
  logic [PW-1:0] prod, scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      ratio_q <= '0;
    end else if (load_i) begin
      duty_q  <= duty_i;
      ratio_q <= ratio_i;
    end
  end

  // fixed-point product, fraction bits dropped (truncation toward zero)
  assign prod    = {{KW{1'b0}}, duty_q} * {{CW{1'b0}}, ratio_q};
  assign scaled  = prod >> KF;
  assign lvl_a_o = duty_q;
  assign lvl_b_o = (scaled > {{KW{1'b0}}, pk_i}) ? pk_i : scaled[CW-1:0];
endmodule

// File: rtl/pwm_phase_cmp.sv
module pwm_phase_cmp #(
  parameter int CW     = 12,
  parameter bit MIRROR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] pk_i,
  input  logic          rising_i,
  input  logic [CW-1:0] level_i,
  output logic          gate_o
);
  logic [CW-1:0] car;
  logic          car_up, on, gate_q;

  generate
    if (MIRROR) begin : g_mirror
      assign car    = pk_i - cnt_i;
      assign car_up = ~rising_i;
    end else begin : g_direct
      assign car    = cnt_i;
      assign car_up = rising_i;
    end
  endgenerate

  // the equality term on the climbing edge gives exactly 2*level cycles
  always_comb begin
    if (level_i == '0)        on = 1'b0;
    else if (level_i >= pk_i) on = 1'b1;
    else                      on = (car < level_i) | ((car == level_i) & car_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= on;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dual_pwm_pkg::*;
#(
  parameter int CW = 12,
  parameter int KW = 9,
  parameter int KF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_i,
  input  logic [KW-1:0] ratio_i,
  input  logic [CW-1:0] period_i,
  output logic          gate_upper_o,
  output logic          gate_lower_o,
  output logic          peak_stb_o
);
  logic [CW-1:0] cnt_w, pk_w, lvl_a, lvl_b;
  logic          rising_w, valley_w, at_peak_w, peak_q;
  logic [CW-1:0] lvl   [NUM_PHASES];
  logic          gates [NUM_PHASES];

  pwm_tri_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .cnt_o(cnt_w), .pk_o(pk_w), .rising_o(rising_w),
    .valley_o(valley_w), .at_peak_o(at_peak_w)
  );

  pwm_duty_shadow #(.CW(CW), .KW(KW), .KF(KF)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load_i(valley_w),
    .duty_i(duty_i), .ratio_i(ratio_i), .pk_i(pk_w),
    .lvl_a_o(lvl_a), .lvl_b_o(lvl_b)
  );

  assign lvl[0] = lvl_a;
  assign lvl[1] = lvl_b;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    pwm_phase_cmp #(.CW(CW), .MIRROR(g != 0)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .pk_i(pk_w),
      .rising_i(rising_w), .level_i(lvl[g]), .gate_o(gates[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= 1'b0;
    else        peak_q <= at_peak_w;
  end

  assign gate_upper_o = gates[0];
  assign gate_lower_o = gates[1];
  assign peak_stb_o   = peak_q;
endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] pk,
  input logic [CW-1:0] lvl_a,
  input logic [CW-1:0] lvl_b,
  input logic          gate_upper_o,
  input logic          gate_lower_o,
  input logic          peak_stb_o
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R1: carrier stays within its peak and moves one step per cycle
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= pk);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ((cnt == $past(cnt) + CW'(1)) || ($past(cnt) == cnt + CW'(1))));

  // R8: strobe never lasts two cycles
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peak_stb_o |=> !peak_stb_o);

  // R7: captured levels hold except across a valley edge
  assert_hold_settings_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(lvl_a) && $stable(pk)));

  // R5: full duty drives the upper gate high
  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a >= pk) |=> gate_upper_o);

  // R4: zero duty drives both gates low
  assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a == '0) |=> (!gate_upper_o && !gate_lower_o));

  // R3: scaled level saturates at the peak
  assert_sat_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_b <= pk);
endmodule

bind dual_pwm_gen dual_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .pk(pk_w),
  .lvl_a(lvl_a), .lvl_b(lvl_b),
  .gate_upper_o(gate_upper_o), .gate_lower_o(gate_lower_o),
  .peak_stb_o(peak_stb_o)
);

// File: tb/dual_pwm_gen_bench.sv
module dual_pwm_gen_bench;
  localparam int CLK_NS = 10;
  localparam int CW = 12;
  localparam int KW = 9;
  localparam int KF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] duty = '0, period = CW'(1);
  logic [KW-1:0] ratio = '0;
  logic gu, gl, pk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dual_pwm_gen #(.CW(CW), .KW(KW), .KF(KF)) u_dual_pwm_gen (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .ratio_i(ratio), .period_i(period),
    .gate_upper_o(gu), .gate_lower_o(gl), .peak_stb_o(pk)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int p_eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int upper_on(input int d, input int p);
    int pe = p_eff(p);
    if (d == 0) return 0;
    if (d >= pe) return 2 * pe;
    return 2 * d;
  endfunction

  function automatic int lower_lvl(input int d, input int k, input int p);
    int s = (d * k) >>> KF;
    return (s > p_eff(p)) ? p_eff(p) : s;
  endfunction

  task automatic wait_strobe();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!pk && t < 20000);
  endtask

  task automatic run_case(input int d, input int k, input int p, input string tag);
    int pe = p_eff(p);
    int lv = lower_lvl(d, k, p);
    int cu = 0, cl = 0, cs = 0, gap = 0;
    @(negedge clk);
    duty = CW'(d); ratio = KW'(k); period = CW'(p);
    wait_strobe();
    wait_strobe();
    // R6: phase relation in the strobe cycle
    check("R6", {tag, " upper at peak"}, int'(gu), (d >= pe) ? 1 : 0);
    check("R6", {tag, " lower at peak"}, int'(gl), (lv > 0) ? 1 : 0);
    // R1: strobe spacing
    do begin
      @(negedge clk);
      gap++;
    end while (!pk && gap < 20000);
    check(p == 0 ? "R10" : "R1", {tag, " strobe spacing"}, gap, 2 * pe);
    for (int i = 0; i < 2 * pe; i++) begin
      @(negedge clk);
      cu += int'(gu); cl += int'(gl); cs += int'(pk);
    end
    check(d == 0 ? "R4" : (d >= pe ? "R5" : "R2"), {tag, " upper on-time"}, cu, upper_on(d, p));
    check(d == 0 ? "R4" : "R3", {tag, " lower on-time"}, cl, 2 * lv);
    check("R8", {tag, " strobes per period"}, cs, 1);
  endtask

  initial begin : main
    int cnt;
    void'($urandom(32'd20240917));
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", "upper in reset", int'(gu), 0);
    check("R9", "lower in reset", int'(gl), 0);
    check("R9", "strobe in reset", int'(pk), 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_case(600, 154, 1000, "nominal");
    run_case(0, 300, 12, "zero duty");          // R4
    run_case(12, 154, 12, "duty at peak");      // R5
    run_case(40, 200, 12, "duty above peak");   // R5
    run_case(10, 400, 12, "lower saturate");    // R3
    run_case(1, 256, 8, "minimum duty");        // R2
    run_case(7, 256, 8, "peak minus one");      // R2
    run_case(1, 511, 0, "zero period");         // R10
    run_case(1, 100, 1, "unit period");         // R1

    // R7: change after a peak must not act before the next valley
    run_case(10, 256, 20, "capture base");
    wait_strobe();
    duty = '0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += int'(gu);
    end
    check("R7", "upper before valley keeps old duty", cnt, 10);
    run_case(0, 256, 20, "capture after");

    for (int it = 0; it < 30; it++) begin
      int p = 1 + int'($urandom % 40);
      int d = int'($urandom % (p + 4));
      int k = int'($urandom % 512);
      run_case(d, k, p, "random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule